// File: doc/BRIEF.md
# USB Device Control and Status Registers

This block is the register file that firmware uses to control a full-speed USB device. It sits on a byte-wide CPU bus with an address, a write strobe, a read strobe and data lines. It holds the device's function address, a small set of power and control bits, and the interrupt flags for the endpoints. Read data is registered and appears on the cycle after the read strobe. Reading a flag register clears the flags it returned.

On the bus side it takes level and pulse inputs from the USB protocol engine: bus idle, reset signaling, start-of-frame, end of transaction, a packet-ready pulse for isochronous IN data, and one event pulse per endpoint. It drives the effective device address, the suspend status, the resume-signaling drive and a zero-length-packet control for isochronous IN endpoints. Suspend detection and resume timing run on their own from a millisecond time base, which is derived from the system clock through the `CLK_PER_MS` parameter.

Top module: `usbd_ctl_regs`

## Requirements
- R1: After `rst_n` is released, every output is 0 and every register reads as 0x00.
- R2: A write to offset 0 stores `cpu_wdata[6:0]` as the pending address and sets the UPDATE flag, bit 7, which is read-only. Offset 0 reads as {UPDATE, pending address}. `dev_addr` keeps its old value until the next `xfer_done_i` pulse. On that pulse the pending address drives `dev_addr` from the next cycle, and UPDATE clears.
- R3: With suspend enable (offset 1, bit 0) set, `suspend_o` sets on the clock edge at which `bus_idle_i` has been high for `IDLE_MS*CLK_PER_MS` consecutive edges. If `bus_idle_i` goes low, or suspend enable is cleared, the count starts again. With suspend enable clear, `suspend_o` never sets. Offset 1, bit 1 reads `suspend_o`.
- R4: `suspend_o` clears after a read of offset 3, or after a write to offset 1 with bit 2 (RESUME) set.
- R5: A write with RESUME=1 while no resume is being driven starts the drive. `resume_o` is then high for exactly `RESUME_MS*CLK_PER_MS` cycles and clears by itself. During the drive, writes to RESUME neither stop it nor restart it. Offset 1, bit 2 reads `resume_o`. At elaboration, `RESUME_MS` must be in the range 1 to 15.
- R6: Offset 1, bit 3 reads the live level of `bus_rst_i`. While `bus_rst_i` is high, the following are all held at 0: the effective address, the pending address, UPDATE, every interrupt flag, and every control and status bit.
- R7: With ISO_WAIT (offset 1, bit 7) set, `iso_zlp_o` goes high the cycle after a `pkt_rdy_i` pulse and goes low the cycle after a `sof_i` pulse. If `pkt_rdy_i` and `sof_i` arrive in the same cycle, SOF wins and `iso_zlp_o` stays low. With ISO_WAIT clear, `iso_zlp_o` stays 0.
- R8: Offset 2 holds the IN-side flags. Bit n is set by `in_ev_i[n]` (bit 0 is endpoint 0, bits 1 to 5 are IN endpoints 1 to 5). A read returns the flags and clears them.
- R9: Offset 4 holds the OUT-side flags in bits 1 to 5, set by `out_ev_i[1]` to `out_ev_i[5]`. Bit 0 reads 0. A read returns the flags and clears them.
- R10: If a flag's event arrives in the same cycle as a read of its register, that read does not show the event. The flag stays set and appears on the next read.
- R11: Unused bits read as 0: offset 1 bits 6:4, offset 2 bits 7:6, offset 4 bits 7:6 and 0, and offsets 5 to 7. Writes to read-only or unused bits, and writes to offsets 2, 3 and 4, have no effect.
- R12: Offset 3 holds the common flags. Bit 0 is set when suspend is entered and bit 1 is set by each `sof_i` pulse. A read returns them and clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 3 | Register offset |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| bus_idle_i | input | 1 | USB bus is idle (level) |
| bus_rst_i | input | 1 | Reset signaling present on the bus (level) |
| sof_i | input | 1 | Start-of-frame token received (pulse) |
| xfer_done_i | input | 1 | Transaction boundary (pulse) |
| pkt_rdy_i | input | 1 | Isochronous IN packet marked ready (pulse) |
| in_ev_i | input | N_EP+1 | Endpoint 0 and IN endpoint event pulses |
| out_ev_i | input | N_EP | OUT endpoint 1..N_EP event pulses |
| dev_addr | output | 7 | Effective device address |
| suspend_o | output | 1 | Suspend mode entered |
| resume_o | output | 1 | Drive resume signaling |
| iso_zlp_o | output | 1 | Send zero-length packets on isochronous IN |

## Verification
The bench sweeps the idle-timer restart over every position at which the idle run can be broken. A counter that failed to restart would enter suspend early, and a counter off by one would enter one edge early or late. It times the resume drive to the cycle while writes arrive in the middle of it, so a drive that a write could cut short or restart shows up as a wrong length. It applies every address value and every flag pattern. It also lands an event on the same edge as the read that clears it: a design that gave the clear priority would lose that flag. Finally, it holds bus reset while state is pending and checks that the address update, the flags and the control bits all come back as 0.

// File: rtl/usbd_regs_pkg.sv
package usbd_regs_pkg;

   typedef enum logic [2:0] {
      SEL_ADDR   = 3'd0,
      SEL_PWR    = 3'd1,
      SEL_INFLG  = 3'd2,
      SEL_COMFLG = 3'd3,
      SEL_OUTFLG = 3'd4
   } reg_sel_e;

   localparam int unsigned PWR_ISO_BIT  = 7;
   localparam int unsigned PWR_RST_BIT  = 3;
   localparam int unsigned PWR_RES_BIT  = 2;
   localparam int unsigned PWR_SUSP_BIT = 1;
   localparam int unsigned PWR_SEN_BIT  = 0;

   localparam int unsigned COM_SUSP_BIT = 0;
   localparam int unsigned COM_SOF_BIT  = 1;
   localparam int unsigned COM_W        = 2;

   typedef struct packed {
      logic iso_wait;
      logic resume;
      logic suspend;
      logic susp_en;
   } pwr_state_t;

endpackage

// File: rtl/usbd_addr_reg.sv
module usbd_addr_reg #(
   parameter int unsigned AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          wr_i,
   input  logic [AW-1:0] wdata_i,
   input  logic          apply_i,
   output logic [AW-1:0] pend_o,
   output logic          upd_o,
   output logic [AW-1:0] eff_o
);

   logic [AW-1:0] pend_q, eff_q;
   logic          upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         eff_q  <= '0;
         upd_q  <= 1'b0;
      end else if (clr_i) begin
         pend_q <= '0;
         eff_q  <= '0;
         upd_q  <= 1'b0;
      end else begin
         if (apply_i && upd_q) eff_q <= pend_q;
         if (wr_i) begin
            pend_q <= wdata_i;
            upd_q  <= 1'b1;
         end else if (apply_i) begin
            upd_q  <= 1'b0;
         end
      end
   end

   assign pend_o = pend_q;
   assign upd_o  = upd_q;
   assign eff_o  = eff_q;

endmodule

// File: rtl/usbd_irq_flags.sv
module usbd_irq_flags #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         rd_i,
   input  logic [W-1:0] ev_i,
   output logic [W-1:0] flags_o
);

   logic [W-1:0] flag_q;

   for (genvar g = 0; g < W; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     flag_q[g] <= 1'b0;
         else if (clr_i) flag_q[g] <= 1'b0;
         else            flag_q[g] <= (flag_q[g] & ~rd_i) | ev_i[g];
      end
   end

   assign flags_o = flag_q;

endmodule

// File: rtl/usbd_pwr_ctl.sv
module usbd_pwr_ctl #(
   parameter int unsigned CLK_PER_MS = 48000,
   parameter int unsigned IDLE_MS    = 3,
   parameter int unsigned RESUME_MS  = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic wr_i,
   input  logic wr_iso_i,
   input  logic wr_res_i,
   input  logic wr_sen_i,
   input  logic com_rd_i,
   input  logic bus_idle_i,
   input  logic sof_i,
   input  logic pkt_rdy_i,
   output usbd_regs_pkg::pwr_state_t st_o,
   output logic susp_ev_o,
   output logic iso_zlp_o
);

   localparam int unsigned IDLE_CYC = IDLE_MS * CLK_PER_MS;
   localparam int unsigned RES_CYC  = RESUME_MS * CLK_PER_MS;
   localparam int unsigned IW       = $clog2(IDLE_CYC + 1);
   localparam int unsigned RW       = $clog2(RES_CYC + 1);

   logic [IW-1:0] idle_cnt;
   logic [RW-1:0] res_cnt;
   logic          iso_q, sen_q, susp_q, res_q, zlp_q;
   logic          susp_hit, res_start, res_wr;

   assign susp_hit  = bus_idle_i && sen_q && (idle_cnt == IW'(IDLE_CYC - 1));
   assign res_wr    = wr_i && wr_res_i;
   assign res_start = res_wr && !res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           idle_cnt <= '0;
      else if (clr_i || !(bus_idle_i && sen_q)) idle_cnt <= '0;
      else if (idle_cnt != IW'(IDLE_CYC))  idle_cnt <= idle_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 susp_q <= 1'b0;
      else if (clr_i)             susp_q <= 1'b0;
      else if (susp_hit)          susp_q <= 1'b1;
      else if (com_rd_i || res_wr) susp_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= 1'b0;
         res_cnt <= '0;
      end else if (clr_i) begin
         res_q   <= 1'b0;
         res_cnt <= '0;
      end else if (res_start) begin
         res_q   <= 1'b1;
         res_cnt <= '0;
      end else if (res_q) begin
         if (res_cnt == RW'(RES_CYC - 1)) res_q <= 1'b0;
         else                             res_cnt <= res_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iso_q <= 1'b0;
         sen_q <= 1'b0;
      end else if (clr_i) begin
         iso_q <= 1'b0;
         sen_q <= 1'b0;
      end else if (wr_i) begin
         iso_q <= wr_iso_i;
         sen_q <= wr_sen_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              zlp_q <= 1'b0;
      else if (clr_i || sof_i) zlp_q <= 1'b0;
      else if (!iso_q)         zlp_q <= 1'b0;
      else if (pkt_rdy_i)      zlp_q <= 1'b1;
   end

   assign st_o.iso_wait = iso_q;
   assign st_o.resume   = res_q;
   assign st_o.suspend  = susp_q;
   assign st_o.susp_en  = sen_q;
   assign susp_ev_o     = susp_hit;
   assign iso_zlp_o     = zlp_q;

endmodule

// File: rtl/usbd_ctl_regs.sv
module usbd_ctl_regs #(
   parameter int unsigned CLK_PER_MS = 48000,
   parameter int unsigned IDLE_MS    = 3,
   parameter int unsigned RESUME_MS  = 10,
   parameter int unsigned N_EP       = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      cpu_addr,
   input  logic            cpu_wr,
   input  logic            cpu_rd,
   input  logic [7:0]      cpu_wdata,
   output logic [7:0]      cpu_rdata,
   input  logic            bus_idle_i,
   input  logic            bus_rst_i,
   input  logic            sof_i,
   input  logic            xfer_done_i,
   input  logic            pkt_rdy_i,
   input  logic [N_EP:0]   in_ev_i,
   input  logic [N_EP:1]   out_ev_i,
   output logic [6:0]      dev_addr,
   output logic            suspend_o,
   output logic            resume_o,
   output logic            iso_zlp_o
);
   import usbd_regs_pkg::*;

   localparam int unsigned AW    = 7;
   localparam int unsigned IN_W  = N_EP + 1;

   if (RESUME_MS < 1 || RESUME_MS > 15) begin : g_bad_resume
      $error("RESUME_MS must lie in 1..15");
   end
   if (N_EP < 1 || N_EP > 6) begin : g_bad_nep
      $error("N_EP must lie in 1..6");
   end
   if (CLK_PER_MS < 1 || IDLE_MS < 1) begin : g_bad_time
      $error("CLK_PER_MS and IDLE_MS must be nonzero");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(cpu_addr);

   logic wr_addr, wr_pwr, rd_in, rd_out, rd_com;
   assign wr_addr = cpu_wr && (sel == SEL_ADDR);
   assign wr_pwr  = cpu_wr && (sel == SEL_PWR);
   assign rd_in   = cpu_rd && (sel == SEL_INFLG);
   assign rd_out  = cpu_rd && (sel == SEL_OUTFLG);
   assign rd_com  = cpu_rd && (sel == SEL_COMFLG);

   logic [AW-1:0]   pend_addr;
   logic            upd;
   pwr_state_t      pst;
   logic            susp_ev;
   logic [IN_W-1:0] in_flags;
   logic [N_EP-1:0] out_flags;
   logic [COM_W-1:0] com_flags, com_ev;

   usbd_addr_reg #(.AW(AW)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (bus_rst_i),
      .wr_i    (wr_addr),
      .wdata_i (cpu_wdata[AW-1:0]),
      .apply_i (xfer_done_i),
      .pend_o  (pend_addr),
      .upd_o   (upd),
      .eff_o   (dev_addr)
   );

   usbd_pwr_ctl #(
      .CLK_PER_MS (CLK_PER_MS),
      .IDLE_MS    (IDLE_MS),
      .RESUME_MS  (RESUME_MS)
   ) u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (bus_rst_i),
      .wr_i       (wr_pwr),
      .wr_iso_i   (cpu_wdata[PWR_ISO_BIT]),
      .wr_res_i   (cpu_wdata[PWR_RES_BIT]),
      .wr_sen_i   (cpu_wdata[PWR_SEN_BIT]),
      .com_rd_i   (rd_com),
      .bus_idle_i (bus_idle_i),
      .sof_i      (sof_i),
      .pkt_rdy_i  (pkt_rdy_i),
      .st_o       (pst),
      .susp_ev_o  (susp_ev),
      .iso_zlp_o  (iso_zlp_o)
   );

   usbd_irq_flags #(.W(IN_W)) u_in_flg (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (bus_rst_i),
      .rd_i    (rd_in),
      .ev_i    (in_ev_i),
      .flags_o (in_flags)
   );

   usbd_irq_flags #(.W(N_EP)) u_out_flg (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (bus_rst_i),
      .rd_i    (rd_out),
      .ev_i    (out_ev_i),
      .flags_o (out_flags)
   );

   always_comb begin
      com_ev               = '0;
      com_ev[COM_SUSP_BIT] = susp_ev;
      com_ev[COM_SOF_BIT]  = sof_i;
   end

   usbd_irq_flags #(.W(COM_W)) u_com_flg (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (bus_rst_i),
      .rd_i    (rd_com),
      .ev_i    (com_ev),
      .flags_o (com_flags)
   );

   logic [7:0] rd_mux, pwr_view;

   always_comb begin
      pwr_view               = '0;
      pwr_view[PWR_ISO_BIT]  = pst.iso_wait;
      pwr_view[PWR_RST_BIT]  = bus_rst_i;
      pwr_view[PWR_RES_BIT]  = pst.resume;
      pwr_view[PWR_SUSP_BIT] = pst.suspend;
      pwr_view[PWR_SEN_BIT]  = pst.susp_en;
   end

   always_comb begin
      case (sel)
         SEL_ADDR:   rd_mux = {upd, pend_addr};
         SEL_PWR:    rd_mux = pwr_view;
         SEL_INFLG:  rd_mux = 8'(in_flags);
         SEL_COMFLG: rd_mux = 8'(com_flags);
         SEL_OUTFLG: rd_mux = 8'({out_flags, 1'b0});
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cpu_rdata <= '0;
      else if (cpu_rd) cpu_rdata <= rd_mux;
   end

   assign suspend_o = pst.suspend;
   assign resume_o  = pst.resume;

endmodule

// File: rtl/usbd_ctl_regs_chk.sv
module usbd_ctl_regs_chk #(
   parameter int unsigned CLK_PER_MS = 48000,
   parameter int unsigned RESUME_MS  = 10
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] cpu_addr,
   input logic       cpu_wr,
   input logic       cpu_rd,
   input logic [7:0] cpu_wdata,
   input logic [7:0] cpu_rdata,
   input logic       bus_idle_i,
   input logic       bus_rst_i,
   input logic       sof_i,
   input logic       xfer_done_i,
   input logic       pkt_rdy_i,
   input logic [6:0] dev_addr,
   input logic       suspend_o,
   input logic       resume_o,
   input logic       iso_zlp_o
);

   localparam int unsigned RES_CYC = RESUME_MS * CLK_PER_MS;

   logic [31:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_cnt <= '0;
      else        run_cnt <= resume_o ? run_cnt + 1 : 32'd0;
   end

   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_addr) |-> ($past(xfer_done_i) || $past(bus_rst_i)));

   p_susp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspend_o) |-> $past(bus_idle_i));

   p_susp_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(suspend_o) |-> ($past(cpu_rd && cpu_addr == 3'd3)
                            || $past(cpu_wr && cpu_addr == 3'd1 && cpu_wdata[2])
                            || $past(bus_rst_i)));

   p_resume_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(resume_o) && !$past(bus_rst_i)) |-> (run_cnt == 32'(RES_CYC)));

   p_busrst_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_i |=> (dev_addr == 7'd0 && !resume_o && !suspend_o && !iso_zlp_o));

   p_zlp_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_zlp_o) |-> ($past(pkt_rdy_i) && !$past(sof_i)));

   p_zlp_sof_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sof_i |=> !iso_zlp_o);

   p_out_bit0_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_addr == 3'd4) |=> (cpu_rdata[0] == 1'b0 && cpu_rdata[7:6] == 2'b00));

endmodule

bind usbd_ctl_regs usbd_ctl_regs_chk #(
   .CLK_PER_MS (CLK_PER_MS),
   .RESUME_MS  (RESUME_MS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_addr    (cpu_addr),
   .cpu_wr      (cpu_wr),
   .cpu_rd      (cpu_rd),
   .cpu_wdata   (cpu_wdata),
   .cpu_rdata   (cpu_rdata),
   .bus_idle_i  (bus_idle_i),
   .bus_rst_i   (bus_rst_i),
   .sof_i       (sof_i),
   .xfer_done_i (xfer_done_i),
   .pkt_rdy_i   (pkt_rdy_i),
   .dev_addr    (dev_addr),
   .suspend_o   (suspend_o),
   .resume_o    (resume_o),
   .iso_zlp_o   (iso_zlp_o)
);

// File: tb/usbd_ctl_regs_tb_top.sv
module usbd_ctl_regs_tb_top;

   localparam int unsigned CPM   = 4;
   localparam int unsigned IDMS  = 3;
   localparam int unsigned RSMS  = 10;
   localparam int unsigned NEP   = 5;
   localparam int unsigned IDLE_N = CPM * IDMS;
   localparam int unsigned RES_N  = CPM * RSMS;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    cpu_addr;
   logic          cpu_wr, cpu_rd;
   logic [7:0]    cpu_wdata;
   logic [7:0]    cpu_rdata;
   logic          bus_idle_i, bus_rst_i, sof_i, xfer_done_i, pkt_rdy_i;
   logic [NEP:0]  in_ev_i;
   logic [NEP:1]  out_ev_i;
   logic [6:0]    dev_addr;
   logic          suspend_o, resume_o, iso_zlp_o;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   usbd_ctl_regs #(
      .CLK_PER_MS (CPM),
      .IDLE_MS    (IDMS),
      .RESUME_MS  (RSMS),
      .N_EP       (NEP)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_wr (cpu_wr),
      .cpu_rd (cpu_rd), .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
      .bus_idle_i (bus_idle_i), .bus_rst_i (bus_rst_i), .sof_i (sof_i),
      .xfer_done_i (xfer_done_i), .pkt_rdy_i (pkt_rdy_i), .in_ev_i (in_ev_i),
      .out_ev_i (out_ev_i), .dev_addr (dev_addr), .suspend_o (suspend_o),
      .resume_o (resume_o), .iso_zlp_o (iso_zlp_o)
   );

   task automatic chk(input string req, input int got, input int exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      cpu_rd = 1'b1; cpu_addr = a;
      @(negedge clk);
      cpu_rd = 1'b0;
      v = cpu_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, int'(v), exp);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [6:0] prev;
      int n;
      rst_n = 1'b0; cpu_addr = '0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = '0;
      bus_idle_i = 1'b0; bus_rst_i = 1'b0; sof_i = 1'b0; xfer_done_i = 1'b0;
      pkt_rdy_i = 1'b0; in_ev_i = '0; out_ev_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 dev_addr", dev_addr, 0);
      chk("R1 suspend", suspend_o, 0);
      chk("R1 resume", resume_o, 0);
      chk("R1 zlp", iso_zlp_o, 0);
      chk("R1 rdata", cpu_rdata, 0);
      for (int a = 0; a < 8; a++) rd_chk("R1 reg", 3'(a), 0);

      // R2 address sweep, bit 7 of write data toggled (R11 ignore)
      prev = 7'd0;
      for (int a = 0; a < 128; a++) begin
         wr(3'd0, {a[0], 7'(a)});
         rd_chk("R2 pending readback", 3'd0, 8'h80 | a);
         chk("R2 old addr held", dev_addr, prev);
         xfer_done_i = 1'b1; @(negedge clk); xfer_done_i = 1'b0;
         chk("R2 addr applied", dev_addr, a);
         rd_chk("R2 update cleared", 3'd0, a);
         prev = 7'(a);
      end
      xfer_done_i = 1'b1; @(negedge clk); xfer_done_i = 1'b0;
      chk("R2 no pending no change", dev_addr, 127);

      // R6 bus reset clears pending state
      wr(3'd0, 8'h55);
      wr(3'd1, 8'h81);
      in_ev_i = '1; out_ev_i = '1; sof_i = 1'b1;
      @(negedge clk);
      in_ev_i = '0; out_ev_i = '0; sof_i = 1'b0;
      bus_rst_i = 1'b1;
      @(negedge clk);
      chk("R6 addr cleared", dev_addr, 0);
      rd_chk("R6 rst bit live", 3'd1, 8'h08);
      bus_rst_i = 1'b0;
      @(negedge clk);
      rd_chk("R6 addr reg", 3'd0, 0);
      rd_chk("R6 pwr reg", 3'd1, 0);
      rd_chk("R6 in flags", 3'd2, 0);
      rd_chk("R6 com flags", 3'd3, 0);
      rd_chk("R6 out flags", 3'd4, 0);

      // R8 IN flags, all patterns
      for (int p = 0; p < 64; p++) begin
         in_ev_i = 6'(p); @(negedge clk); in_ev_i = '0;
         rd_chk("R8 in flags", 3'd2, p);
         rd_chk("R8 cleared by read", 3'd2, 0);
      end
      // R9 OUT flags, all patterns
      for (int p = 0; p < 32; p++) begin
         out_ev_i = 5'(p); @(negedge clk); out_ev_i = '0;
         rd_chk("R9 out flags", 3'd4, p << 1);
         rd_chk("R9 cleared by read", 3'd4, 0);
      end

      // R10 event coinciding with read
      cpu_rd = 1'b1; cpu_addr = 3'd2; in_ev_i = 6'b001000;
      @(negedge clk);
      cpu_rd = 1'b0; in_ev_i = '0;
      chk("R10 read misses same-cycle event", cpu_rdata, 0);
      rd_chk("R10 flag kept", 3'd2, 8'h08);
      cpu_rd = 1'b1; cpu_addr = 3'd4; out_ev_i = 5'b10000;
      @(negedge clk);
      cpu_rd = 1'b0; out_ev_i = '0;
      chk("R10 out read misses event", cpu_rdata, 0);
      rd_chk("R10 out flag kept", 3'd4, 8'h20);

      // R11 writes to flag registers and reserved bits
      in_ev_i = 6'b000011; @(negedge clk); in_ev_i = '0;
      wr(3'd2, 8'h00);
      wr(3'd4, 8'hFF);
      wr(3'd3, 8'hFF);
      rd_chk("R11 in flags unaffected by write", 3'd2, 8'h03);
      rd_chk("R11 out flags unaffected by write", 3'd4, 0);
      rd_chk("R11 com unaffected by write", 3'd3, 0);
      wr(3'd1, 8'hFF);
      rd_chk("R11 pwr reserved zero", 3'd1, 8'h85);
      wr(3'd1, 8'h00);
      chk("R5 zero write ignored", resume_o, 1);
      n = 0;
      while (resume_o && n < 200) begin n++; @(negedge clk); end
      chk("R5 resume ended", resume_o, 0);
      rd_chk("R11 unused offset 5", 3'd5, 0);
      rd_chk("R11 unused offset 7", 3'd7, 0);

      // R3 idle timer restart sweep
      wr(3'd1, 8'h01);
      for (int k = 1; k < IDLE_N; k++) begin
         bus_idle_i = 1'b1; repeat (k) @(negedge clk);
         bus_idle_i = 1'b0; @(negedge clk);
         bus_idle_i = 1'b1; repeat (IDLE_N - 1) @(negedge clk);
         chk("R3 not yet suspended", suspend_o, 0);
         @(negedge clk);
         chk("R3 suspended on count", suspend_o, 1);
         rd_chk("R12 suspend event", 3'd3, 8'h01);
         chk("R4 cleared by common read", suspend_o, 0);
         bus_idle_i = 1'b0; @(negedge clk);
      end
      wr(3'd1, 8'h00);
      bus_idle_i = 1'b1; repeat (3 * IDLE_N) @(negedge clk);
      chk("R3 disabled no suspend", suspend_o, 0);
      bus_idle_i = 1'b0;

      // R4 resume write clears suspend, R5 exact length
      wr(3'd1, 8'h01);
      bus_idle_i = 1'b1; repeat (IDLE_N) @(negedge clk);
      chk("R3 suspended", suspend_o, 1);
      wr(3'd1, 8'h05);
      chk("R4 cleared by resume", suspend_o, 0);
      bus_idle_i = 1'b0;
      n = 0;
      while (resume_o && n < 200) begin
         n++;
         cpu_wr = (n == 10) || (n == 20);
         cpu_addr = 3'd1;
         cpu_wdata = (n == 20) ? 8'h05 : 8'h01;
         @(negedge clk);
      end
      cpu_wr = 1'b0;
      chk("R5 resume length", n, RES_N);
      rd_chk("R12 com after suspend", 3'd3, 8'h01);

      // R7 iso zero-length packet control
      wr(3'd1, 8'h80);
      pkt_rdy_i = 1'b1; @(negedge clk); pkt_rdy_i = 1'b0;
      chk("R7 zlp on ready", iso_zlp_o, 1);
      repeat (5) @(negedge clk);
      chk("R7 zlp held", iso_zlp_o, 1);
      sof_i = 1'b1; @(negedge clk); sof_i = 1'b0;
      chk("R7 zlp off at sof", iso_zlp_o, 0);
      rd_chk("R12 sof event", 3'd3, 8'h02);
      rd_chk("R12 sof cleared", 3'd3, 0);
      pkt_rdy_i = 1'b1; sof_i = 1'b1; @(negedge clk);
      pkt_rdy_i = 1'b0; sof_i = 1'b0;
      chk("R7 sof wins", iso_zlp_o, 0);
      wr(3'd1, 8'h00);
      pkt_rdy_i = 1'b1; @(negedge clk); pkt_rdy_i = 1'b0;
      chk("R7 disabled no zlp", iso_zlp_o, 0);

      finish_run();
   end

endmodule